// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address by looking up a single-level page table kept in memory. A requester hands it one virtual address together with a read/write flag. The block then does four things. It computes where the matching table entry lives. It fetches that entry through a simple memory port. It judges the entry's presence and write-protection flags. Finally it answers with either a physical address and its cache-bypass attribute, or with a page fault or a protection fault.

When a successful access leaves the entry's usage flags out of date, the block stores the updated entry back before it answers. This keeps the table usable by a page-replacement policy. Faults are reported and nothing more is done: whatever fixes the table does so on its own, and the requester then sends the same address again.

The memory port takes a request under a valid/ready handshake. It returns exactly one response pulse for every accepted request, reads and writes alike, after any number of cycles. The table base input must stay steady while a translation is in flight.

Top module: `pt_xlate`

## Requirements
- R1: On a successful translation, `rsp_paddr` is the 3-bit frame (entry bits 2:0) in bits 14:12 and the virtual address bits 11:0 unchanged in bits 11:0. The page number is virtual address bits 15:12.
- R2: The entry fetch is a read (`mem_req_we`=0) at address `pt_base + 2*page_number`. A request held without ready keeps its address and direction.
- R3: An entry with its presence bit (bit 8) at 0 gives `rsp_page_fault`=1 and `rsp_prot_fault`=0. It issues no memory write, so the stored entry is unchanged.
- R4: When the presence bit is 1 and bit 9 is 1 (read-only), a write gives `rsp_prot_fault`=1, issues no memory write, and leaves the entry unchanged. A read of such a page succeeds.
- R5: A successful read sets bit 10 (accessed) in the stored entry.
- R6: A successful write sets both bit 10 (accessed) and bit 11 (modified) in the stored entry.
- R7: The entry is written back exactly once when bit 10 or bit 11 changes, and never when both already hold their target values.
- R8: `rsp_uncached` copies entry bit 12 on a successful translation and is 0 on a fault.
- R9: `req_ready` stays low from acceptance until the result pulse. The result pulse comes only after the response to any write-back has returned.
- R10: Sending again an address that faulted, after its entry was made present, completes as a normal hit.
- R11: In reset and right after it, `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_base | input | 16 | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 15 | Physical address (0 on fault) |
| rsp_uncached | output | 1 | Access must bypass the cache |
| rsp_page_fault | output | 1 | Entry not present |
| rsp_prot_fault | output | 1 | Write to read-only page |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write-back, 0 = entry fetch |
| mem_req_addr | output | 16 | Entry byte address |
| mem_req_wdata | output | 16 | Updated entry |
| mem_rsp_valid | input | 1 | Memory response pulse |
| mem_rsp_rdata | input | 16 | Fetched entry |

## Verification
A wrong latched entry or a wrong verdict shows up at the single result pulse of the same translation. It appears as a wrong frame, a wrong fault flag or a wrong cache-bypass flag, and it also leaves a stored entry that differs from the expected one once that transaction is over. A sequencer that skips or repeats the write-back is caught by counting memory writes per translation. A sequencer that answers too early is caught because the write response is still outstanding at the pulse. Randomised entries, random memory stalls and response delays drive every flag combination, and directed cases cover the fault-then-retry sequence.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    localparam int VA_W   = 16;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 3;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int PTE_W  = 16;
    localparam int PTE_BYTES_LOG2 = 1;

    localparam int B_PRESENT = 8;
    localparam int B_RDONLY  = 9;
    localparam int B_USED    = 10;
    localparam int B_DIRTY   = 11;
    localparam int B_NOCACHE = 12;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_FWAIT, S_JUDGE, S_WBACK, S_WWAIT, S_DONE
    } xl_state_e;

    typedef struct packed {
        logic              pg_fault;
        logic              ro_fault;
        logic              need_wb;
        logic              nocache;
        logic [PFN_W-1:0]  pfn;
        logic [PTE_W-1:0]  new_pte;
    } verdict_t;

    function automatic logic [PTE_W-1:0] mark_used(input logic [PTE_W-1:0] pte,
                                                   input logic wr);
        logic [PTE_W-1:0] r;
        r = pte;
        r[B_USED] = 1'b1;
        if (wr) r[B_DIRTY] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pte_addr_gen.sv
module pte_addr_gen
    import pgx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]    base,
    input  logic [VPN_W-1:0] vpn,
    output logic [AW-1:0]    pte_addr
);
    localparam int PAD = AW - VPN_W - PTE_BYTES_LOG2;
    logic [AW-1:0] scaled;
    always_comb begin
        scaled   = {{PAD{1'b0}}, vpn, {PTE_BYTES_LOG2{1'b0}}};
        pte_addr = base + scaled;
    end
endmodule

// File: rtl/pte_judge.sv
module pte_judge
    import pgx_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    output verdict_t         verdict
);
    logic present, ro_hit, ok;
    logic [PTE_W-1:0] upd;
    always_comb begin
        present = pte[B_PRESENT];
        ro_hit  = present && pte[B_RDONLY] && is_write;
        ok      = present && !ro_hit;
        upd     = mark_used(pte, is_write);
        verdict.pg_fault = !present;
        verdict.ro_fault = ro_hit;
        verdict.need_wb  = ok && (upd != pte);
        verdict.nocache  = ok && pte[B_NOCACHE];
        verdict.pfn      = ok ? pte[PFN_W-1:0] : '0;
        verdict.new_pte  = upd;
    end
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
    import pgx_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEM_AW-1:0] pt_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_uncached,
    output logic              rsp_page_fault,
    output logic              rsp_prot_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [MEM_AW-1:0] mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_rdata
);
    xl_state_e         state;
    logic [VA_W-1:0]   vaddr_q;
    logic              wr_q;
    logic [PTE_W-1:0]  pte_q;
    verdict_t          vd_now, vd_q;
    logic [MEM_AW-1:0] ent_addr;

    pte_addr_gen #(.AW(MEM_AW)) u_addr (
        .base     (pt_base),
        .vpn      (vaddr_q[VA_W-1:OFF_W]),
        .pte_addr (ent_addr)
    );

    pte_judge u_judge (
        .pte      (pte_q),
        .is_write (wr_q),
        .verdict  (vd_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            vaddr_q <= '0;
            wr_q    <= 1'b0;
            pte_q   <= '0;
            vd_q    <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    wr_q    <= req_write;
                    state   <= S_FETCH;
                end
                S_FETCH: if (mem_req_ready) state <= S_FWAIT;
                S_FWAIT: if (mem_rsp_valid) begin
                    pte_q <= mem_rsp_rdata;
                    state <= S_JUDGE;
                end
                S_JUDGE: begin
                    vd_q  <= vd_now;
                    state <= vd_now.need_wb ? S_WBACK : S_DONE;
                end
                S_WBACK: if (mem_req_ready) state <= S_WWAIT;
                S_WWAIT: if (mem_rsp_valid) state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready      = (state == S_IDLE);
        mem_req_valid  = (state == S_FETCH) || (state == S_WBACK);
        mem_req_we     = (state == S_WBACK);
        mem_req_addr   = ent_addr;
        mem_req_wdata  = vd_q.new_pte;
        rsp_valid      = (state == S_DONE);
        rsp_page_fault = rsp_valid && vd_q.pg_fault;
        rsp_prot_fault = rsp_valid && vd_q.ro_fault;
        rsp_uncached   = rsp_valid && vd_q.nocache;
        rsp_paddr      = (vd_q.pg_fault || vd_q.ro_fault) ? '0
                         : {vd_q.pfn, vaddr_q[OFF_W-1:0]};
    end

    // R2: a stalled memory request holds its address and direction
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // R3: never both faults on one result
    assert_one_fault_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_page_fault && rsp_prot_fault));

    // R1: offset passes through on a hit
    assert_offset_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_page_fault && !rsp_prot_fault) |->
        (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

    // R7: a write-back always changes a present entry
    assert_wb_change_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we) |->
        ((mem_req_wdata != pte_q) && pte_q[B_PRESENT]));

    // R9: no new request accepted while memory traffic is in flight
    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);
endmodule

// File: tb/pt_xlate_tb_top.sv
module pt_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pt_base;
    logic        req_valid, req_ready, req_write;
    logic [15:0] req_vaddr;
    logic        rsp_valid, rsp_uncached, rsp_page_fault, rsp_prot_fault;
    logic [14:0] rsp_paddr;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [15:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [15:0] mem_rsp_rdata;

    always #2 clk = ~clk;

    pt_xlate dut_i (
        .clk(clk), .rst(rst), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_uncached(rsp_uncached), .rsp_page_fault(rsp_page_fault),
        .rsp_prot_fault(rsp_prot_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    // memory model: word store, random ready, random response delay
    logic [15:0] mem [0:255];
    logic        pending;
    logic [1:0]  dly;
    logic [15:0] pend_data, last_rd_addr;
    int          wr_count;
    logic        host_we;
    logic [7:0]  host_idx;
    logic [15:0] host_data;

    always @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0; dly <= '0; mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0; mem_req_ready <= 1'b0; wr_count <= 0;
            last_rd_addr <= '0; pend_data <= '0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (host_we) mem[host_idx] <= host_data;
            if (pending) begin
                if (dly == 0) begin
                    mem_rsp_valid <= 1'b1; mem_rsp_rdata <= pend_data; pending <= 1'b0;
                end else dly <= dly - 1'b1;
            end else if (mem_req_valid && mem_req_ready) begin
                pending <= 1'b1;
                dly     <= 2'($urandom % 3);
                if (mem_req_we) begin
                    mem[mem_req_addr[8:1]] <= mem_req_wdata;
                    wr_count  <= wr_count + 1;
                    pend_data <= '0;
                end else begin
                    pend_data    <= mem[mem_req_addr[8:1]];
                    last_rd_addr <= mem_req_addr;
                end
            end
            mem_req_ready <= ($urandom % 4 != 0) && !pending &&
                             !(mem_req_valid && mem_req_ready);
        end
    end

    int checks = 0, errors = 0, cycles = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [7:0] ent_idx(input logic [3:0] vpn);
        return 8'((pt_base + {11'd0, vpn, 1'b0}) >> 1);
    endfunction

    function automatic logic [15:0] exp_after(input logic [15:0] pte, input bit wr);
        logic [15:0] r = pte;
        if (pte[8] && !(pte[9] && wr)) begin
            r[10] = 1'b1;
            if (wr) r[11] = 1'b1;
        end
        return r;
    endfunction

    task automatic set_pte(input logic [3:0] vpn, input logic [15:0] val);
        @(negedge clk);
        host_we = 1'b1; host_idx = ent_idx(vpn); host_data = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    logic [14:0] got_pa;
    logic        got_nc, got_pf, got_rf, busy_bad, pend_at_done;
    int          got_wr;

    task automatic translate(input logic [15:0] va, input bit wr);
        int start_wr, n;
        @(negedge clk);
        start_wr = wr_count;
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        busy_bad = 1'b0; n = 0;
        while (!rsp_valid && n < 200) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk); n++;
        end
        if (n >= 200) chk(1'b0, "R9 timeout", 32'(n), 32'd200);
        got_pa = rsp_paddr; got_nc = rsp_uncached;
        got_pf = rsp_page_fault; got_rf = rsp_prot_fault;
        pend_at_done = pending;
        got_wr = wr_count - start_wr;
    endtask

    // full check of one translation against the computed expectation
    task automatic run_one(input logic [15:0] va, input bit wr, input logic [15:0] pte);
        logic [3:0] vpn = va[15:12];
        logic       ok  = pte[8] && !(pte[9] && wr);
        logic [15:0] after = exp_after(pte, wr);
        set_pte(vpn, pte);
        translate(va, wr);
        chk(got_pf == !pte[8], "R3 page fault flag", 32'(got_pf), 32'(!pte[8]));
        chk(got_rf == (pte[8] && pte[9] && wr), "R4 protection fault flag",
            32'(got_rf), 32'(pte[8] && pte[9] && wr));
        chk(got_pa == (ok ? {pte[2:0], va[11:0]} : 15'd0), "R1 physical address",
            32'(got_pa), 32'(ok ? {pte[2:0], va[11:0]} : 15'd0));
        chk(got_nc == (ok && pte[12]), "R8 uncached", 32'(got_nc), 32'(ok && pte[12]));
        chk(last_rd_addr == pt_base + {11'd0, vpn, 1'b0}, "R2 entry address",
            32'(last_rd_addr), 32'(pt_base + {11'd0, vpn, 1'b0}));
        chk(got_wr == ((after != pte) ? 1 : 0), "R7 write-back count",
            32'(got_wr), 32'((after != pte) ? 1 : 0));
        chk(!busy_bad && !pend_at_done, "R9 ready low and write acked before result",
            32'({busy_bad, pend_at_done}), 32'd0);
        @(negedge clk);
        chk(mem[ent_idx(vpn)] == after, wr ? "R6 stored entry" : "R5 stored entry",
            32'(mem[ent_idx(vpn)]), 32'(after));
    endtask

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1; pt_base = 16'h0040;
        req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        host_we = 1'b0; host_idx = '0; host_data = '0;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R11 reset state",
            32'({req_ready, rsp_valid, mem_req_valid}), 32'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R11 after reset",
            32'({req_ready, rsp_valid, mem_req_valid}), 32'b100);

        // R3 then R10: absent page faults, becomes present, retry hits
        run_one(16'h3ABC, 1'b0, 16'h0005);
        run_one(16'h3ABC, 1'b0, 16'h0105);
        chk(!got_pf && got_pa == 15'h5ABC, "R10 retry hit", 32'(got_pa), 32'h5ABC);
        // R4: read-only read ok, write refused
        run_one(16'h7123, 1'b0, 16'h0302);
        run_one(16'h7123, 1'b1, 16'h0702);
        // R7: already accessed/modified, no write-back
        run_one(16'h9FFF, 1'b0, 16'h0501);
        run_one(16'h9000, 1'b1, 16'h0D07);
        // R6 and R8: write on clean uncached page
        run_one(16'hF001, 1'b1, 16'h1106);

        // R2 with a second base
        pt_base = 16'h0100;
        run_one(16'h2222, 1'b0, 16'h0103);

        pt_base = 16'h0040;
        for (int i = 0; i < 150; i++) begin
            logic [15:0] va  = 16'($urandom);
            logic [15:0] pte = {3'b000, 5'($urandom), 5'b00000, 3'($urandom)};
            run_one(va, 1'($urandom), pte);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule